// File: doc/BRIEF.md
# Synthesizer Divider Chain with Test Observation Mux

This block is the digital divider section of a frequency synthesizer. It turns three clock streams, the VCO, the reference and a slow serial clock, into the signals the rest of the loop and the board need. These are a reference compare clock at one sixteenth of the reference, a feedback compare clock at the VCO rate divided by twice a programmable M, and a main output at the VCO rate divided by 1, 2, 4 or 8 with 50% duty. A 3-bit test code routes one of eight internal signals to a test pin, and an enable gates the main output.

The block runs in a single fast system clock `clk`. Each external clock arrives as a one-cycle strobe marking its edges. `vco_ce` marks every VCO edge (both rising and falling), so one VCO period is two strobes. `ref_ce` marks each rising edge of the reference. `sck_ce` marks each rising edge of the serial clock. Divider values change without truncated pulses: the M counter takes a new value only at its terminal count, and the output divider takes a new code only at the start of an output period.

Top module: `vco_divchain`

## Requirements
- R1: While `rst` is high, and after its release until the first strobe, `fout_o`, `test_o`, `ref_cmp_o` and `fb_cmp_o` are all 0.
- R2: `ref_cmp_o` has a period of 16 `ref_ce` strobes and is high for 8 of them. It changes only in the cycle after a `ref_ce` strobe.
- R3: `fb_cmp_o` has a period of 2M VCO rising edges (4M `vco_ce` strobes) and is high for half of it. An `m_val` of 0 acts as 1.
- R4: `n_code` sets the `fout_o` period in `vco_ce` strobes: 00 gives 4 (VCO/2), 01 gives 8 (VCO/4), 10 gives 16 (VCO/8) and 11 gives 2 (VCO/1).
- R5: `fout_o` is high for exactly half of its period for every `n_code`.
- R6: When `out_en` is low, `fout_o` is 0 from the next cycle, while the internal divider keeps running.
- R7: `t_code` 001 drives `test_o` high and 101 drives it low. `t_code` 000 makes `test_o` equal `shift_bit` one cycle later.
- R8: `t_code` 010 puts the divide-by-16 reference on `test_o`, with a period of 16 `ref_ce` strobes.
- R9: `t_code` 011 puts a narrow M-divider pulse on `test_o`. Its period is 2M VCO rising edges and its width is one VCO period (2 `vco_ce` strobes), so it is not 50% duty.
- R10: `t_code` 110 steps the M counter on `sck_ce` instead of the VCO. `test_o` then has a period of 2M `sck_ce` strobes and a width of one, and `vco_ce` has no effect on `fb_cmp_o`.
- R11: `t_code` 100 puts the undivided main output on `test_o`, with the period of R4, regardless of `out_en`.
- R12: `t_code` 111 puts the main output divided by 4 on `test_o`, a period of four `fout_o` periods.
- R13: A new `m_val` is taken only at the M counter's terminal count. The feedback phase in progress completes with the old value.
- R14: A new `n_code` is taken only when the main output rises. The half-period in progress and the next one complete with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| vco_ce | input | 1 | Strobe, one per VCO edge |
| ref_ce | input | 1 | Strobe, one per reference rising edge |
| sck_ce | input | 1 | Strobe, one per serial clock rising edge |
| m_val | input | M_W | Feedback divider value M |
| n_code | input | 2 | Output divider code |
| t_code | input | 3 | Test output select |
| shift_bit | input | 1 | Serial configuration register output bit |
| out_en | input | 1 | Main output enable |
| fout_o | output | 1 | Gated main output |
| test_o | output | 1 | Test observation output |
| ref_cmp_o | output | 1 | Reference divided by 16 |
| fb_cmp_o | output | 1 | VCO divided by 2M |

## Verification
Every cycle, the assertions check the gating of the main output by the enable, the constant and shift-bit test codes, and that the reference and serial-mode feedback outputs move only when their own strobe came. The divide ratios, the duty cycles, the narrow M pulses, the divide-by-4 tap and the glitch-free reload at terminal counts depend on long windows of strobes. Only the bench's scenarios can show these: it measures periods and half-periods in strobe counts, under random M, codes and strobe rates, and under directed value changes made mid-phase.

// File: rtl/vco_divchain_pkg.sv
package vco_divchain_pkg;

  localparam int TSEL_W = 3;
  localparam int HALF_W = 4;

  typedef enum logic [TSEL_W-1:0] {
    TSEL_SHIFT = 3'd0,
    TSEL_ONE   = 3'd1,
    TSEL_REF   = 3'd2,
    TSEL_MVCO  = 3'd3,
    TSEL_FOUT  = 3'd4,
    TSEL_ZERO  = 3'd5,
    TSEL_MSCK  = 3'd6,
    TSEL_FOUT4 = 3'd7
  } tsel_e;

  // Half-period of the main output, counted in VCO edges.
  function automatic logic [HALF_W-1:0] half_edges(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd2;
      2'b01:   return 4'd4;
      2'b10:   return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/ref_prescaler.sv
module ref_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic div_q
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (step) begin
      if (cnt == CW'(HALF - 1)) begin
        cnt   <= '0;
        div_q <= ~div_q;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/m_counter.sv
module m_counter #(
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic [M_W-1:0] m_val,
  output logic           fb_q,
  output logic           pulse_q
);
  logic [M_W-1:0] cnt;
  logic [M_W-1:0] reload;
  logic           term;

  // A zero value behaves as one.
  assign reload = (m_val == '0) ? '0 : m_val - M_W'(1);
  assign term   = step && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      fb_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else if (term) begin
      cnt     <= reload;
      fb_q    <= ~fb_q;
      pulse_q <= ~fb_q;
    end else if (step) begin
      cnt     <= cnt - M_W'(1);
      pulse_q <= 1'b0;
    end
  end
endmodule

// File: rtl/out_divider.sv
module out_divider
  import vco_divchain_pkg::*;
#(
  parameter int POST = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] code,
  output logic       fout_q,
  output logic       fpost_q
);
  localparam int PW = (POST > 1) ? $clog2(POST) : 1;

  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] n_act;
  logic [HALF_W-1:0] n_new;
  logic              edge_now;
  logic [PW-1:0]     post_cnt;

  assign n_new    = half_edges(code);
  assign edge_now = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      n_act  <= 4'd1;
      fout_q <= 1'b0;
    end else if (edge_now) begin
      fout_q <= ~fout_q;
      if (!fout_q) begin
        n_act <= n_new;
        cnt   <= n_new - HALF_W'(1);
      end else begin
        cnt <= n_act - HALF_W'(1);
      end
    end else if (tick) begin
      cnt <= cnt - HALF_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) post_cnt <= '0;
    else if (edge_now && !fout_q) post_cnt <= post_cnt + PW'(1);
  end

  generate
    if (POST > 1) begin : g_post
      assign fpost_q = post_cnt[PW-1];
    end else begin : g_nopost
      assign fpost_q = fout_q;
    end
  endgenerate
endmodule

// File: rtl/test_mux.sv
module test_mux #(
  parameter int SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SEL_W-1:0]      sel,
  input  logic [(1<<SEL_W)-1:0] srcs,
  output logic                  test_q
);
  always_ff @(posedge clk) begin
    if (rst) test_q <= 1'b0;
    else     test_q <= srcs[sel];
  end
endmodule

// File: rtl/vco_divchain.sv
module vco_divchain
  import vco_divchain_pkg::*;
#(
  parameter int REF_DIV = 16,
  parameter int M_W     = 9,
  parameter int POST    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vco_ce,
  input  logic              ref_ce,
  input  logic              sck_ce,
  input  logic [M_W-1:0]    m_val,
  input  logic [1:0]        n_code,
  input  logic [TSEL_W-1:0] t_code,
  input  logic              shift_bit,
  input  logic              out_en,
  output logic              fout_o,
  output logic              test_o,
  output logic              ref_cmp_o,
  output logic              fb_cmp_o
);
  localparam int NSRC = 1 << TSEL_W;

  logic            vco_ph;
  logic            vco_rise;
  logic            m_step;
  logic            m_pulse;
  logic            fout_raw;
  logic            fout_post;
  logic [NSRC-1:0] srcs;

  // VCO phase: strobes alternate rising and falling, first one rising.
  always_ff @(posedge clk) begin
    if (rst)         vco_ph <= 1'b0;
    else if (vco_ce) vco_ph <= ~vco_ph;
  end
  assign vco_rise = vco_ce && !vco_ph;

  assign m_step = (t_code == TSEL_MSCK) ? sck_ce : vco_rise;

  ref_prescaler #(.DIV(REF_DIV)) u_ref (
    .clk(clk), .rst(rst), .step(ref_ce), .div_q(ref_cmp_o)
  );

  m_counter #(.M_W(M_W)) u_mcnt (
    .clk(clk), .rst(rst), .step(m_step), .m_val(m_val),
    .fb_q(fb_cmp_o), .pulse_q(m_pulse)
  );

  out_divider #(.POST(POST)) u_odiv (
    .clk(clk), .rst(rst), .tick(vco_ce), .code(n_code),
    .fout_q(fout_raw), .fpost_q(fout_post)
  );

  // Index equals the tsel_e code value.
  assign srcs = {fout_post, m_pulse, 1'b0, fout_raw,
                 m_pulse, ref_cmp_o, 1'b1, shift_bit};

  test_mux #(.SEL_W(TSEL_W)) u_tmux (
    .clk(clk), .rst(rst), .sel(t_code), .srcs(srcs), .test_q(test_o)
  );

  always_ff @(posedge clk) begin
    if (rst) fout_o <= 1'b0;
    else     fout_o <= out_en && fout_raw;
  end
endmodule

// File: rtl/vco_divchain_chk.sv
module vco_divchain_chk (
  input logic       clk,
  input logic       rst,
  input logic       ref_ce,
  input logic       sck_ce,
  input logic [2:0] t_code,
  input logic       shift_bit,
  input logic       out_en,
  input logic       fout_o,
  input logic       test_o,
  input logic       ref_cmp_o,
  input logic       fb_cmp_o
);
  // R6
  gate_low_chk: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !fout_o);

  // R7
  tie_high_chk: assert property (@(posedge clk) disable iff (rst)
    (t_code == 3'd1) |=> test_o);

  // R7
  tie_low_chk: assert property (@(posedge clk) disable iff (rst)
    (t_code == 3'd5) |=> !test_o);

  // R7
  shift_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (t_code == 3'd0) |=> (test_o == $past(shift_bit)));

  // R2
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_ce |=> $stable(ref_cmp_o));

  // R10
  sck_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((t_code == 3'd6) && !sck_ce) |=> $stable(fb_cmp_o));
endmodule

bind vco_divchain vco_divchain_chk u_chk (
  .clk(clk), .rst(rst), .ref_ce(ref_ce), .sck_ce(sck_ce),
  .t_code(t_code), .shift_bit(shift_bit), .out_en(out_en),
  .fout_o(fout_o), .test_o(test_o), .ref_cmp_o(ref_cmp_o),
  .fb_cmp_o(fb_cmp_o)
);

// File: tb/tb_vco_divchain.sv
module tb_vco_divchain;
  localparam int CLK_PERIOD = 10;
  localparam int M_W = 9;
  localparam int GUARD = 20000;

  logic clk = 1'b0;
  logic rst;
  logic vco_ce, ref_ce, sck_ce;
  logic [M_W-1:0] m_val;
  logic [1:0] n_code;
  logic [2:0] t_code;
  logic shift_bit, out_en;
  logic fout_o, test_o, ref_cmp_o, fb_cmp_o;

  vco_divchain #(.M_W(M_W)) dut (
    .clk(clk), .rst(rst), .vco_ce(vco_ce), .ref_ce(ref_ce), .sck_ce(sck_ce),
    .m_val(m_val), .n_code(n_code), .t_code(t_code), .shift_bit(shift_bit),
    .out_en(out_en), .fout_o(fout_o), .test_o(test_o),
    .ref_cmp_o(ref_cmp_o), .fb_cmp_o(fb_cmp_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  int tick_v = 0, tick_r = 0, tick_s = 0;
  int kv = 0, kr = 0, ks = 0;
  int pv = 0, pr = 0, ps = 0;
  logic s_fout, s_test, s_ref, s_fb;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // Sample outputs, then drive periodic strobes for the next edge.
  task automatic step();
    @(negedge clk);
    s_fout = fout_o; s_test = test_o; s_ref = ref_cmp_o; s_fb = fb_cmp_o;
    vco_ce = 1'b0; ref_ce = 1'b0; sck_ce = 1'b0;
    if (kv != 0) begin pv++; if (pv >= kv) begin pv = 0; vco_ce = 1'b1; tick_v++; end end
    if (kr != 0) begin pr++; if (pr >= kr) begin pr = 0; ref_ce = 1'b1; tick_r++; end end
    if (ks != 0) begin ps++; if (ps >= ks) begin ps = 0; sck_ce = 1'b1; tick_s++; end end
  endtask

  function automatic logic cur(input int sel);
    case (sel)
      0: return s_fout;
      1: return s_test;
      2: return s_ref;
      default: return s_fb;
    endcase
  endfunction

  function automatic int ticks(input int src);
    case (src)
      0: return tick_v;
      1: return tick_r;
      default: return tick_s;
    endcase
  endfunction

  task automatic wait_edge(input int sel, input logic to_val, output bit ok);
    logic prev;
    int g = 0;
    do begin
      prev = cur(sel);
      step();
      g++;
    end while (!(prev != to_val && cur(sel) == to_val) && g < GUARD);
    ok = (g < GUARD);
  endtask

  // Period and high time of an output, in strobes of source src.
  task automatic measure(input int sel, input int src, output int per, output int hi);
    bit ok;
    int t0, t1;
    per = -1; hi = -1;
    wait_edge(sel, 1'b1, ok); if (!ok) return;
    t0 = ticks(src);
    wait_edge(sel, 1'b0, ok); if (!ok) return;
    t1 = ticks(src);
    wait_edge(sel, 1'b1, ok); if (!ok) return;
    per = ticks(src) - t0;
    hi = t1 - t0;
  endtask

  function automatic int exp_half(input logic [1:0] c);
    case (c)
      2'b00: return 2;
      2'b01: return 4;
      2'b10: return 8;
      default: return 1;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int per, hi, m, k, t0, cnt;
    int d[4];
    bit ok;
    logic [1:0] c;
    void'($urandom(32'd4711));
    rst = 1'b1; vco_ce = 0; ref_ce = 0; sck_ce = 0;
    m_val = 9'd4; n_code = 2'b00; t_code = 3'd0; shift_bit = 0; out_en = 1;
    repeat (4) step();
    // R1 reset state
    check_eq("R1 fout", s_fout, 0); check_eq("R1 test", s_test, 0);
    check_eq("R1 ref", s_ref, 0);   check_eq("R1 fb", s_fb, 0);
    rst = 1'b0;
    repeat (5) step();
    check_eq("R1 idle after release", {s_fout, s_test, s_ref, s_fb}, 0);

    // R2 reference prescaler
    for (int i = 0; i < 3; i++) begin
      kr = (i == 0) ? 1 : 1 + $urandom_range(0, 2);
      measure(2, 1, per, hi);
      check_eq("R2 ref period", per, 16);
      check_eq("R2 ref high", hi, 8);
    end

    // R3 feedback divider, directed and random M, including M=0
    t_code = 3'd4;
    for (int i = 0; i < 7; i++) begin
      case (i)
        0: m = 2; 1: m = 3; 2: m = 0; 3: m = 1;
        default: m = $urandom_range(2, 20);
      endcase
      m_val = M_W'(m);
      kv = 1 + $urandom_range(0, 2);
      measure(3, 0, per, hi);
      measure(3, 0, per, hi);
      if (m == 0) m = 1;
      check_eq("R3 fb period", per, 4 * m);
      check_eq("R3 fb high", hi, 2 * m);
    end

    // R4 R5 R11 R12 output divider codes
    for (int i = 0; i < 4; i++) begin
      c = 2'(i);
      n_code = c; t_code = 3'd4; out_en = 1;
      kv = 1 + $urandom_range(0, 1);
      measure(0, 0, per, hi);
      measure(0, 0, per, hi);
      check_eq("R4 fout period", per, 2 * exp_half(c));
      check_eq("R5 fout duty", hi, exp_half(c));
      measure(1, 0, per, hi);
      check_eq("R11 test fout period", per, 2 * exp_half(c));
      t_code = 3'd7;
      measure(1, 0, per, hi);
      measure(1, 0, per, hi);
      check_eq("R12 fout/4 period", per, 8 * exp_half(c));
    end

    // R6 gating, with R11 showing the divider still runs
    n_code = 2'b01; t_code = 3'd4; kv = 1; out_en = 0;
    step(); step();
    ok = 1; cnt = 0;
    for (int i = 0; i < 200; i++) begin
      logic pt;
      pt = s_test;
      step();
      if (s_fout) ok = 0;
      if (!pt && s_test) cnt++;
    end
    check(ok, "R6 gated fout low", s_fout, 0);
    check(cnt > 0, "R11 test toggles while gated", cnt, 25);
    out_en = 1;

    // R7 constants and shift bit
    t_code = 3'd1; step(); step();
    check_eq("R7 code 001 high", s_test, 1);
    t_code = 3'd5; step(); step();
    check_eq("R7 code 101 low", s_test, 0);
    t_code = 3'd0;
    for (int i = 0; i < 12; i++) begin
      logic b;
      b = 1'($urandom_range(0, 1));
      shift_bit = b;
      step();
      check_eq("R7 shift follow", s_test, b);
    end

    // R8 reference on test pin
    t_code = 3'd2; kr = 2;
    measure(1, 1, per, hi);
    check_eq("R8 test ref period", per, 16);

    // R9 narrow M pulse from VCO
    t_code = 3'd3; m_val = 9'd5; kv = 1;
    measure(1, 0, per, hi); measure(1, 0, per, hi);
    check_eq("R9 pulse period", per, 20);
    check_eq("R9 pulse width", hi, 2);

    // R10 M counter on serial clock
    m = $urandom_range(3, 12);
    m_val = M_W'(m); t_code = 3'd6; kv = 1; ks = 2;
    measure(1, 2, per, hi); measure(1, 2, per, hi);
    check_eq("R10 sck pulse period", per, 2 * m);
    check_eq("R10 sck pulse width", hi, 1);
    measure(3, 2, per, hi);
    check_eq("R10 fb period in sck", per, 2 * m);
    ks = 0; step(); step();
    begin
      logic f0;
      f0 = s_fb; ok = 1;
      for (int i = 0; i < 100; i++) begin step(); if (s_fb != f0) ok = 0; end
      check(ok, "R10 vco ignored in sck mode", s_fb, f0);
    end

    // R13 M change mid-phase
    t_code = 3'd4; kv = 1; m_val = 9'd4;
    measure(3, 0, per, hi);
    wait_edge(3, 1'b1, ok);
    t0 = ticks(0);
    m_val = 9'd7;
    wait_edge(3, 1'b0, ok);
    check_eq("R13 old phase kept", ticks(0) - t0, 8);
    t0 = ticks(0);
    wait_edge(3, 1'b1, ok);
    check_eq("R13 new low phase", ticks(0) - t0, 14);
    t0 = ticks(0);
    wait_edge(3, 1'b0, ok);
    check_eq("R13 new high phase", ticks(0) - t0, 14);

    // R14 N change while output high
    n_code = 2'b00; kv = 1;
    measure(0, 0, per, hi);
    wait_edge(0, 1'b1, ok);
    n_code = 2'b10;
    wait_edge(0, 1'b0, ok);
    for (int i = 0; i < 4; i++) begin
      t0 = ticks(0);
      wait_edge(0, (i % 2 == 0) ? 1'b1 : 1'b0, ok);
      d[i] = ticks(0) - t0;
    end
    check_eq("R14 low phase keeps old", d[0], 2);
    check_eq("R14 new high", d[1], 8);
    check_eq("R14 new low", d[2], 8);
    check_eq("R14 next high", d[3], 8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule